// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This controller drives one logical AUX request to completion through a lower-level channel engine that can only run single transactions. After a `go` it asks the engine for an attempt. It reads the outcome the engine reports, which is a set of channel status flags, a three-bit reply code and a received byte count. From that outcome it either finishes with success, finishes with failure, or starts another attempt. A retry may start at once or after a timed pause.

Each kind of trouble draws on its own retry budget: short reads, defers, target-side defers, invalid replies and timeouts. Some outcomes clear other budgets. A timeout that arrives after any defer has been seen is treated as a further defer. An outer cap on the number of attempts applies whatever the per-cause budgets say. Pauses are counted in microsecond ticks taken from a prescaled clock. The defer pause is set in milliseconds at the `go` input and is latched together with the request direction and length.

Top module: `aux_rty_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, `start_o`, `done_o` and `busy_o` are low.
- R2: When attempt number MAX_TRIES ends without a final verdict, the controller finishes with failure and starts no further attempt.
- R3: Outcomes are classified in this order. Acquire failure comes first, then disconnect; both end with failure at once. Receive timeout comes next. After that, any bit of `res_rx_err_i` makes the outcome an invalid reply, and so does a byte count of zero. Only an outcome with none of these is a completed reply, whose code is then examined.
- R4: Reply code 0 (acknowledge) finishes with success. The exception is a read (`rd_i`=1) where byte count minus one differs from `len_i`. That case increments a short-read counter, fails when it reaches ACK_LIM (7), and otherwise retries after ACK_WAIT_US ticks.
- R5: Code 2 (link defer) and code 4 (bridged defer) set a sticky defer-seen flag and increment the defer counter. The request fails when that counter reaches DFR_LIM (7); otherwise it retries after `defer_ms_i`×US_PER_MS ticks, or at once when that product is zero.
- R6: Code 3 (bridged NACK) increments the same defer counter under the same limit and retries with no pause.
- R7: Code 5 (target defer) clears the defer counter and increments a separate counter. The request fails when that counter reaches I2CD_LIM (7); otherwise it retries with no pause.
- R8: Code 1 (link NACK), code 6 (disconnect reply) and code 7 (reserved) end with failure at once.
- R9: An invalid reply increments its own counter, fails when it reaches INV_LIM (2), and otherwise retries after INV_WAIT_US ticks.
- R10: A timeout with defer-seen set counts against the defer budget and pauses for the defer time. Without defer-seen it increments a timeout counter, fails when that reaches TMO_LIM (3), and otherwise retries with no pause.
- R11: Every completed reply clears the timeout and invalid-reply counters.
- R12: After the accepting clock edge, an immediate retry raises `start_o` on the next edge. A pause of N ticks delays that by N×CLK_PER_US+1 further clocks.
- R13: `start_o` is a one-cycle pulse per attempt and `done_o` a one-cycle pulse with `ok_o` valid. `start_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Begin a request (taken when idle) |
| rd_i | input | 1 | Request is a read |
| len_i | input | LEN_W | Requested payload length in bytes |
| defer_ms_i | input | DMS_W | Defer pause in milliseconds |
| start_o | output | 1 | Launch one engine transaction |
| res_valid_i | input | 1 | Engine outcome valid |
| res_acq_fail_i | input | 1 | Engine could not be acquired |
| res_discon_i | input | 1 | Sink disconnected |
| res_timeout_i | input | 1 | Receive timeout |
| res_rx_err_i | input | ERR_W | Stop, detect and level errors |
| res_code_i | input | 3 | Reply code |
| res_count_i | input | LEN_W+1 | Received bytes including the reply byte |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request finished (pulse) |
| ok_o | output | 1 | Finished with success |

## Verification
The bench raises MAX_TRIES to 12. With that cap, a run of six defers followed by a target defer and another defer reaches success, which shows that the defer budget is cleared. Alternating invalid replies with short reads reaches the outer cap while no per-cause budget is exhausted. CLK_PER_US is set to 2, US_PER_MS to 3, ACK_WAIT_US to 5 and INV_WAIT_US to 4. These values keep every pause to a few clocks, so the exact pause lengths for each cause can be measured against the tick formula.

// File: rtl/aux_rty_pkg.sv
package aux_rty_pkg;

  typedef enum logic [2:0] {
    CL_OK,
    CL_ACQ,
    CL_DISC,
    CL_TMO,
    CL_INV
  } chan_cls_e;

  typedef enum logic [1:0] {
    V_RETRY,
    V_OK,
    V_FAIL
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESP,
    ST_PAUSE
  } rty_state_e;

  localparam logic [2:0] RC_ACK       = 3'd0;
  localparam logic [2:0] RC_LINK_NACK = 3'd1;
  localparam logic [2:0] RC_LINK_DFR  = 3'd2;
  localparam logic [2:0] RC_BR_NACK   = 3'd3;
  localparam logic [2:0] RC_BR_DFR    = 3'd4;
  localparam logic [2:0] RC_TGT_DFR   = 3'd5;

endpackage

// File: rtl/aux_rty_classify.sv
module aux_rty_classify
  import aux_rty_pkg::*;
#(
  parameter int ERR_W  = 3,
  parameter int RCNT_W = 6
) (
  input  logic              acq_fail_i,
  input  logic              discon_i,
  input  logic              timeout_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  input  logic [RCNT_W-1:0] count_i,
  output chan_cls_e         cls_o
);

  // Priority order of the channel status checks.
  always_comb begin
    if (acq_fail_i)            cls_o = CL_ACQ;
    else if (discon_i)         cls_o = CL_DISC;
    else if (timeout_i)        cls_o = CL_TMO;
    else if (|rx_err_i)        cls_o = CL_INV;
    else if (count_i == '0)    cls_o = CL_INV;
    else                       cls_o = CL_OK;
  end

endmodule

// File: rtl/aux_rty_timer.sv
module aux_rty_timer #(
  parameter int CLK_PER_US = 50,
  parameter int WAIT_W     = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] us_i,
  output logic              zero_o
);

  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PLAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0]     pre_q;
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      cnt_q <= us_i;
    end else if (cnt_q != '0) begin
      if (pre_q == PLAST) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/aux_rty_ctrl.sv
module aux_rty_ctrl
  import aux_rty_pkg::*;
#(
  parameter int LEN_W       = 5,
  parameter int DMS_W       = 8,
  parameter int ERR_W       = 3,
  parameter int CLK_PER_US  = 50,
  parameter int US_PER_MS   = 1000,
  parameter int ACK_WAIT_US = 300,
  parameter int INV_WAIT_US = 400,
  parameter int MAX_TRIES   = 7,
  parameter int ACK_LIM     = 7,
  parameter int DFR_LIM     = 7,
  parameter int I2CD_LIM    = 7,
  parameter int INV_LIM     = 2,
  parameter int TMO_LIM     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic             rd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DMS_W-1:0] defer_ms_i,
  output logic             start_o,
  input  logic             res_valid_i,
  input  logic             res_acq_fail_i,
  input  logic             res_discon_i,
  input  logic             res_timeout_i,
  input  logic [ERR_W-1:0] res_rx_err_i,
  input  logic [2:0]       res_code_i,
  input  logic [LEN_W:0]   res_count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o
);

  localparam int RCNT_W = LEN_W + 1;
  localparam int CTR_W  = $clog2(MAX_TRIES + 1);
  localparam int WAIT_W = $clog2((2 ** DMS_W) * US_PER_MS + ACK_WAIT_US + INV_WAIT_US + 1);

  rty_state_e       state_q;
  logic             start_q, done_q, ok_q;
  logic             rd_q;
  logic [LEN_W-1:0] len_q;
  logic [DMS_W-1:0] dms_q;
  logic [CTR_W-1:0] try_q, ack_q, dfr_q, tgt_q, inv_q, tmo_q;
  logic             seen_q;

  logic [CTR_W-1:0]  ack_n, dfr_n, tgt_n, inv_n, tmo_n;
  logic              seen_n;
  verdict_e          verdict;
  logic [WAIT_W-1:0] wait_us, dfr_wait;
  chan_cls_e         cls;
  logic              acc, fin_fail, tmr_load, tmr_zero;

  aux_rty_classify #(.ERR_W(ERR_W), .RCNT_W(RCNT_W)) u_cls (
    .acq_fail_i (res_acq_fail_i),
    .discon_i   (res_discon_i),
    .timeout_i  (res_timeout_i),
    .rx_err_i   (res_rx_err_i),
    .count_i    (res_count_i),
    .cls_o      (cls)
  );

  assign dfr_wait = WAIT_W'(dms_q) * WAIT_W'(US_PER_MS);

  // Per-cause budget bookkeeping and verdict for the current outcome.
  always_comb begin
    ack_n   = ack_q;
    dfr_n   = dfr_q;
    tgt_n   = tgt_q;
    inv_n   = inv_q;
    tmo_n   = tmo_q;
    seen_n  = seen_q;
    verdict = V_RETRY;
    wait_us = '0;
    unique case (cls)
      CL_ACQ, CL_DISC: verdict = V_FAIL;
      CL_INV: begin
        inv_n = inv_q + 1'b1;
        if (inv_n >= CTR_W'(INV_LIM)) verdict = V_FAIL;
        else wait_us = WAIT_W'(INV_WAIT_US);
      end
      CL_TMO: begin
        if (seen_q) begin
          dfr_n = dfr_q + 1'b1;
          if (dfr_n >= CTR_W'(DFR_LIM)) verdict = V_FAIL;
          else wait_us = dfr_wait;
        end else begin
          tmo_n = tmo_q + 1'b1;
          if (tmo_n >= CTR_W'(TMO_LIM)) verdict = V_FAIL;
        end
      end
      CL_OK: begin
        tmo_n = '0;
        inv_n = '0;
        case (res_code_i)
          RC_ACK: begin
            if (rd_q && (res_count_i != ({1'b0, len_q} + 1'b1))) begin
              ack_n = ack_q + 1'b1;
              if (ack_n >= CTR_W'(ACK_LIM)) verdict = V_FAIL;
              else wait_us = WAIT_W'(ACK_WAIT_US);
            end else begin
              verdict = V_OK;
            end
          end
          RC_LINK_DFR, RC_BR_DFR: begin
            seen_n = 1'b1;
            dfr_n  = dfr_q + 1'b1;
            if (dfr_n >= CTR_W'(DFR_LIM)) verdict = V_FAIL;
            else wait_us = dfr_wait;
          end
          RC_BR_NACK: begin
            dfr_n = dfr_q + 1'b1;
            if (dfr_n >= CTR_W'(DFR_LIM)) verdict = V_FAIL;
          end
          RC_TGT_DFR: begin
            dfr_n = '0;
            tgt_n = tgt_q + 1'b1;
            if (tgt_n >= CTR_W'(I2CD_LIM)) verdict = V_FAIL;
          end
          default: verdict = V_FAIL;
        endcase
      end
      default: verdict = V_FAIL;
    endcase
  end

  assign acc      = (state_q == ST_RESP) && res_valid_i && !start_q;
  assign fin_fail = (verdict == V_FAIL) ||
                    ((verdict == V_RETRY) && (try_q >= CTR_W'(MAX_TRIES)));
  assign tmr_load = acc && !fin_fail && (verdict == V_RETRY) && (wait_us != '0);

  aux_rty_timer #(.CLK_PER_US(CLK_PER_US), .WAIT_W(WAIT_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .us_i   (wait_us),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      rd_q    <= 1'b0;
      len_q   <= '0;
      dms_q   <= '0;
      try_q   <= '0;
      ack_q   <= '0;
      dfr_q   <= '0;
      tgt_q   <= '0;
      inv_q   <= '0;
      tmo_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            rd_q    <= rd_i;
            len_q   <= len_i;
            dms_q   <= defer_ms_i;
            ack_q   <= '0;
            dfr_q   <= '0;
            tgt_q   <= '0;
            inv_q   <= '0;
            tmo_q   <= '0;
            seen_q  <= 1'b0;
            ok_q    <= 1'b0;
            try_q   <= CTR_W'(1);
            start_q <= 1'b1;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (acc) begin
            ack_q  <= ack_n;
            dfr_q  <= dfr_n;
            tgt_q  <= tgt_n;
            inv_q  <= inv_n;
            tmo_q  <= tmo_n;
            seen_q <= seen_n;
            if (verdict == V_OK) begin
              done_q  <= 1'b1;
              ok_q    <= 1'b1;
              state_q <= ST_IDLE;
            end else if (fin_fail) begin
              done_q  <= 1'b1;
              ok_q    <= 1'b0;
              state_q <= ST_IDLE;
            end else if (wait_us == '0) begin
              start_q <= 1'b1;
              try_q   <= try_q + 1'b1;
            end else begin
              state_q <= ST_PAUSE;
            end
          end
        end
        ST_PAUSE: begin
          if (tmr_zero) begin
            start_q <= 1'b1;
            try_q   <= try_q + 1'b1;
            state_q <= ST_RESP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o = start_q;
  assign done_o  = done_q;
  assign ok_o    = ok_q;
  assign busy_o  = (state_q != ST_IDLE);

endmodule

// File: rtl/aux_rty_chk.sv
module aux_rty_chk #(
  parameter int LEN_W     = 5,
  parameter int ERR_W     = 3,
  parameter int MAX_TRIES = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             go_i,
  input logic             start_o,
  input logic             res_valid_i,
  input logic             res_acq_fail_i,
  input logic             res_discon_i,
  input logic             res_timeout_i,
  input logic [ERR_W-1:0] res_rx_err_i,
  input logic [2:0]       res_code_i,
  input logic [LEN_W:0]   res_count_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             ok_o
);

  localparam int TW = $clog2(MAX_TRIES + 1) + 1;

  logic [TW-1:0] tries_seen;
  logic          pend;
  logic          taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      tries_seen <= '0;
      pend       <= 1'b0;
    end else begin
      if (go_i && !busy_o) tries_seen <= '0;
      else if (start_o)    tries_seen <= tries_seen + 1'b1;
      if (start_o)                   pend <= 1'b1;
      else if (pend && res_valid_i)  pend <= 1'b0;
    end
  end

  assign taken = pend && res_valid_i && !start_o;

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!start_o && !done_o && !busy_o));

  a_r2_attempt_cap: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (tries_seen < TW'(MAX_TRIES)));

  a_r3_discon_fails: assert property (@(posedge clk) disable iff (rst)
    (taken && res_discon_i) |=> (done_o && !ok_o));

  a_r8_nack_fails: assert property (@(posedge clk) disable iff (rst)
    (taken && !res_acq_fail_i && !res_discon_i && !res_timeout_i &&
     (res_rx_err_i == '0) && (res_count_i != '0) && (res_code_i == 3'd1))
    |=> (done_o && !ok_o));

  a_r13_start_pulse: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r13_start_busy: assert property (@(posedge clk) disable iff (rst)
    start_o |-> busy_o);

endmodule

bind aux_rty_ctrl aux_rty_chk #(
  .LEN_W(LEN_W), .ERR_W(ERR_W), .MAX_TRIES(MAX_TRIES)
) u_chk (
  .clk(clk), .rst(rst), .go_i(go_i), .start_o(start_o),
  .res_valid_i(res_valid_i), .res_acq_fail_i(res_acq_fail_i),
  .res_discon_i(res_discon_i), .res_timeout_i(res_timeout_i),
  .res_rx_err_i(res_rx_err_i), .res_code_i(res_code_i),
  .res_count_i(res_count_i), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o)
);

// File: tb/tb_aux_rty_ctrl.sv
module tb_aux_rty_ctrl;

  localparam int LEN_W = 5;
  localparam int ERR_W = 3;
  localparam int MAXT  = 12;
  localparam int CPU   = 2;
  localparam int UPM   = 3;
  localparam int AWAIT = 5;
  localparam int IWAIT = 4;
  localparam int RSP_W = 13;
  localparam int SEQ_W = MAXT * RSP_W;

  typedef logic [RSP_W-1:0] rsp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, rd = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [7:0] dms = '0;
  logic rv = 1'b0, racq = 1'b0, rdis = 1'b0, rtmo = 1'b0;
  logic [ERR_W-1:0] rerr = '0;
  logic [2:0] rcode = '0;
  logic [LEN_W:0] rcnt = '0;
  logic start, busy, done, ok;

  always #10 clk = ~clk;

  aux_rty_ctrl #(
    .LEN_W(LEN_W), .ERR_W(ERR_W), .CLK_PER_US(CPU), .US_PER_MS(UPM),
    .ACK_WAIT_US(AWAIT), .INV_WAIT_US(IWAIT), .MAX_TRIES(MAXT)
  ) dut (
    .clk(clk), .rst(rst), .go_i(go), .rd_i(rd), .len_i(len), .defer_ms_i(dms),
    .start_o(start), .res_valid_i(rv), .res_acq_fail_i(racq),
    .res_discon_i(rdis), .res_timeout_i(rtmo), .res_rx_err_i(rerr),
    .res_code_i(rcode), .res_count_i(rcnt), .busy_o(busy), .done_o(done),
    .ok_o(ok)
  );

  // Outcome packing: [12] acquire fail, [11] disconnect, [10] timeout,
  // [9] receive error, [8:6] reply code, [5:0] byte count.
  function automatic rsp_t rp(input logic a, input logic d, input logic t,
                              input logic e, input logic [2:0] c, input int n);
    return {a, d, t, e, c, 6'(n)};
  endfunction

  function automatic logic [SEQ_W-1:0] at(input rsp_t r, input int i);
    return SEQ_W'(r) << (i * RSP_W);
  endfunction

  function automatic logic [SEQ_W-1:0] rep(input rsp_t r, input int n);
    logic [SEQ_W-1:0] s;
    s = '0;
    for (int i = 0; i < n; i++) s = s | at(r, i);
    return s;
  endfunction

  localparam rsp_t TMO = rp(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 0);
  localparam rsp_t INV = rp(1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1);
  localparam rsp_t ZC  = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 0);
  localparam rsp_t DSC = rp(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 0);
  localparam rsp_t ACQ = rp(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 0);
  localparam rsp_t NAK = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1);
  localparam rsp_t ADF = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1);
  localparam rsp_t LNK = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1);
  localparam rsp_t LDF = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1);
  localparam rsp_t I2D = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 1);
  localparam rsp_t DRP = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd6, 1);
  localparam rsp_t RSV = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 1);
  localparam rsp_t A1  = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1);
  localparam rsp_t A3  = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3);
  localparam rsp_t A5  = rp(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5);
  localparam rsp_t DT  = rp(1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 0);
  localparam rsp_t TE  = rp(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 1);
  localparam rsp_t EA  = rp(1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1);

  typedef struct packed {
    logic             rd;
    logic [LEN_W-1:0] len;
    logic [7:0]       dms;
    logic [SEQ_W-1:0] seq;
    logic [4:0]       n_exp;
    logic             ok_exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd3, 8'd0, rep(A1, 1),  5'd1,  1'b1},  // R4 write ack
    '{1'b1, 5'd4, 8'd0, rep(A5, 1),  5'd1,  1'b1},  // R4 full read
    '{1'b1, 5'd4, 8'd0, at(A3, 0) | at(A5, 1), 5'd2, 1'b1},  // R4 short then full
    '{1'b1, 5'd2, 8'd0, rep(A1, 7),  5'd7,  1'b0},  // R4 short-read budget
    '{1'b0, 5'd1, 8'd0, rep(NAK, 1), 5'd1,  1'b0},  // R8 link nack
    '{1'b0, 5'd1, 8'd0, rep(DRP, 1), 5'd1,  1'b0},  // R8 disconnect reply
    '{1'b0, 5'd1, 8'd0, rep(RSV, 1), 5'd1,  1'b0},  // R8 reserved code
    '{1'b0, 5'd1, 8'd0, rep(DSC, 1), 5'd1,  1'b0},  // R3 disconnect status
    '{1'b0, 5'd1, 8'd0, rep(ACQ, 1), 5'd1,  1'b0},  // R3 acquire failure
    '{1'b0, 5'd1, 8'd0, rep(TMO, 3), 5'd3,  1'b0},  // R10 timeout budget
    '{1'b0, 5'd1, 8'd0, rep(INV, 2), 5'd2,  1'b0},  // R9 invalid budget
    '{1'b0, 5'd1, 8'd0, rep(ZC, 2),  5'd2,  1'b0},  // R3 zero count invalid
    '{1'b0, 5'd1, 8'd0, rep(DT, 1),  5'd1,  1'b0},  // R3 disconnect over timeout
    '{1'b0, 5'd1, 8'd0, rep(TE, 3),  5'd3,  1'b0},  // R3 timeout over rx error
    '{1'b0, 5'd1, 8'd0, rep(EA, 2),  5'd2,  1'b0},  // R3 rx error over ack
    '{1'b1, 5'd2, 8'd0, rep(TMO, 2) | at(A1, 2) | at(TMO, 3) | at(TMO, 4) | at(A3, 5),
      5'd6, 1'b1},                                   // R11 timeouts cleared
    '{1'b1, 5'd2, 8'd0, at(INV, 0) | at(A1, 1) | at(INV, 2) | at(A3, 3),
      5'd4, 1'b1},                                   // R11 invalid cleared
    '{1'b0, 5'd1, 8'd0, rep(ADF, 7), 5'd7,  1'b0},  // R5 link defer budget
    '{1'b0, 5'd1, 8'd0, rep(LDF, 7), 5'd7,  1'b0},  // R5 bridged defer budget
    '{1'b0, 5'd1, 8'd0, rep(LNK, 7), 5'd7,  1'b0},  // R6 bridged nack budget
    '{1'b0, 5'd1, 8'd0, rep(ADF, 3) | (rep(LNK, 4) << (3 * RSP_W)), 5'd7, 1'b0},  // R6 shared
    '{1'b0, 5'd1, 8'd0, at(ADF, 0) | (rep(TMO, 6) << RSP_W), 5'd7, 1'b0},  // R10 after defer
    '{1'b0, 5'd1, 8'd0, rep(I2D, 7), 5'd7,  1'b0},  // R7 target defer budget
    '{1'b0, 5'd1, 8'd0, rep(ADF, 6) | at(I2D, 6) | at(ADF, 7) | at(A1, 8), 5'd9, 1'b1},  // R7 clears defer
    '{1'b1, 5'd2, 8'd0, rep(at(INV, 0) | at(A1, 1), 1) | (rep(INV, 0)) |
      at(INV, 0) | at(A1, 1) | at(INV, 2) | at(A1, 3) | at(INV, 4) | at(A1, 5) |
      at(INV, 6) | at(A1, 7) | at(INV, 8) | at(A1, 9) | at(INV, 10) | at(A1, 11),
      5'd12, 1'b0}                                   // R2 outer cap
  };

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int gap_log [16];

  task automatic check(input bit c, input string req, input int act, input int exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic run_seq(input logic r, input logic [LEN_W-1:0] l,
                         input logic [7:0] d, input logic [SEQ_W-1:0] seq,
                         output int n_att, output logic okv, output logic fin);
    rsp_t cur;
    int g;
    n_att = 0;
    fin = 1'b0;
    okv = 1'b0;
    @(negedge clk);
    go = 1'b1; rd = r; len = l; dms = d;
    @(negedge clk);
    go = 1'b0;
    while (start) begin
      cur = (n_att < MAXT) ? seq[n_att*RSP_W +: RSP_W] : ZC;
      n_att++;
      @(negedge clk);
      rv = 1'b1; racq = cur[12]; rdis = cur[11]; rtmo = cur[10];
      rerr = ERR_W'(cur[9]); rcode = cur[8:6]; rcnt = cur[5:0];
      @(negedge clk);
      rv = 1'b0;
      g = 1;
      while (!start && !done && g < 4000) begin
        @(negedge clk);
        g++;
      end
      if (n_att <= 16) gap_log[n_att-1] = g;
    end
    if (done) begin
      fin = 1'b1;
      okv = ok;
      @(negedge clk);
      check(!done, "R13 done pulse", int'(done), 0);
    end
  endtask

  initial begin
    int na;
    logic okv, fin;
    repeat (3) @(negedge clk);
    check(!start && !done && !busy, "R1 reset outputs", int'({start, done, busy}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!start && !done && !busy, "R1 idle after reset", int'({start, done, busy}), 0);

    for (int v = 0; v < NV; v++) begin
      run_seq(VEC[v].rd, VEC[v].len, VEC[v].dms, VEC[v].seq, na, okv, fin);
      check(fin, $sformatf("R13 vec %0d finished", v), int'(fin), 1);
      check(na == int'(VEC[v].n_exp), $sformatf("R2-count vec %0d attempts", v),
            na, int'(VEC[v].n_exp));
      check(okv == VEC[v].ok_exp, $sformatf("R4 R5 R7 R8 R9 R10 vec %0d verdict", v),
            int'(okv), int'(VEC[v].ok_exp));
    end

    // R12 R4: short-read pause
    run_seq(1'b1, 5'd2, 8'd0, at(A1, 0) | at(A3, 1), na, okv, fin);
    check(gap_log[0] == AWAIT * CPU + 2, "R4 R12 short-read pause", gap_log[0], AWAIT * CPU + 2);
    check(okv && na == 2, "R4 short then ok", na, 2);

    // R9 R12: invalid-reply pause
    run_seq(1'b0, 5'd1, 8'd0, at(INV, 0) | at(A1, 1), na, okv, fin);
    check(gap_log[0] == IWAIT * CPU + 2, "R9 R12 invalid pause", gap_log[0], IWAIT * CPU + 2);

    // R5 R6 R10: defer pause, bridged nack without pause, timeout after defer
    run_seq(1'b0, 5'd1, 8'd2, at(ADF, 0) | at(LNK, 1) | at(TMO, 2) | at(A1, 3), na, okv, fin);
    check(gap_log[0] == 2 * UPM * CPU + 2, "R5 defer pause", gap_log[0], 2 * UPM * CPU + 2);
    check(gap_log[1] == 1, "R6 no pause", gap_log[1], 1);
    check(gap_log[2] == 2 * UPM * CPU + 2, "R10 timeout after defer pause", gap_log[2], 2 * UPM * CPU + 2);
    check(okv && na == 4, "R10 defer path ok", na, 4);

    // R10: plain timeout retries at once
    run_seq(1'b0, 5'd1, 8'd2, at(TMO, 0) | at(A1, 1), na, okv, fin);
    check(gap_log[0] == 1, "R10 timeout no pause", gap_log[0], 1);

    // R5: zero defer time means immediate retry
    run_seq(1'b0, 5'd1, 8'd0, at(LDF, 0) | at(A1, 1), na, okv, fin);
    check(gap_log[0] == 1, "R5 zero defer", gap_log[0], 1);

    // R7: target defer does not pause
    run_seq(1'b0, 5'd1, 8'd2, at(I2D, 0) | at(A1, 1), na, okv, fin);
    check(gap_log[0] == 1, "R7 no pause", gap_log[0], 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule